// File: doc/BRIEF.md
# Serial Configuration Word Transmitter

This block sits on the host side of a programmable clock synthesizer. It takes the synthesizer's configuration as parallel fields: the crystal load trim, the duty-cycle threshold select, the second-output function, the output divider code, the feedback divider and the reference divider. When it sees a one-cycle start request, it captures the fields, packs them into one 24-bit word and shifts that word out, most significant bit first, on a data line and a serial clock line. The latch-enable line stays low for the whole shift. Once the last bit is in, the block raises the latch-enable line for a pulse of programmed width.

Every timing interval is a parameterized count of system clock cycles: how long data is held before a serial clock rise, how long the serial clock stays high, the gap before the latch pulse, and the latch pulse width. With those counts the receiver's nanosecond minimums can be met at any system clock rate. After the latch pulse, an optional settling counter lets the synthesizer's loop lock before the block reports completion. A feedback divider below the smallest legal value is refused with an error pulse. A reference divider of zero is passed through, because it selects the bypass path.

Top module: `cfg_word_tx`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `ser_clk`, `ser_dat`, `ser_stb`, `busy`, `done` and `err` are all low.
- R2: A transfer sends exactly 24 bits, most significant first, formed as {cap_sel[1:0], duty_sel, aux_sel[1:0], div_sel[2:0], vco_div[8:0], ref_div[6:0]}. The receiver takes each bit on a rising `ser_clk`. For cap_sel=00, duty_sel=1, aux_sel=10, div_sel=001, vco_div=276 and ref_div=59, the bit stream is 00110001 10001010 00111011.
- R3: `ser_stb` is never high while `ser_clk` is high. It rises only after all 24 rising edges of `ser_clk` in the transfer have been sent.
- R4: `ser_dat` holds its value for at least SETUP_CYC system clock cycles before each rising edge of `ser_clk`.
- R5: `ser_clk` stays high for at least HOLD_CYC cycles, and `ser_dat` does not change while `ser_clk` is high.
- R6: At least WAIT_CYC cycles pass between the final falling edge of `ser_clk` and the rise of `ser_stb`. `ser_stb` then stays high for at least STRB_CYC cycles.
- R7: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse that comes exactly LOCK_CYC cycles after `ser_stb` falls, and `busy` is low in that same cycle.
- R8: A start with vco_div below MIN_VDW (4) gives a one-cycle `err` pulse in the next cycle, and no transfer, `busy` or `done` follows. A ref_div of 0 is accepted and sent unchanged.
- R9: A start that arrives while `busy` is high has no effect: no `err`, no second transfer, and the word being sent is the one captured at the accepted start, even if the input fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send the current fields |
| cap_sel | input | 2 | Crystal load trim code |
| duty_sel | input | 1 | Duty-cycle threshold select |
| aux_sel | input | 2 | Second-output function code |
| div_sel | input | 3 | Output divider code |
| vco_div | input | 9 | Feedback divider value |
| ref_div | input | 7 | Reference divider value |
| busy | output | 1 | Transfer or settling in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused request |
| ser_clk | output | 1 | Serial shift clock |
| ser_dat | output | 1 | Serial data |
| ser_stb | output | 1 | Latch-enable pulse |

## Verification
The word path is exercised four ways. The known 24-bit example pins down the field order. An all-ones word and an alternating word expose any bit-slip or swapped field. A word at the divider boundaries (feedback divider 4, reference divider 0) shows that legal edge values are not refused. A passive monitor follows every transfer and measures each setup, high, gap and pulse interval in cycles, so a shortened phase is caught separately from a wrong bit. Refused requests and starts issued mid-transfer with changed fields tell rejection apart from silent ignoring: the first must produce `err` alone, the second must produce nothing at all.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_GAP,
    ST_STRB,
    ST_LOCK
  } cwt_state_e;

  function automatic int cwt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cwt_pack.sv
module cwt_pack #(
  parameter int CAP_W   = 2,
  parameter int AUX_W   = 2,
  parameter int DIV_W   = 3,
  parameter int VDW_W   = 9,
  parameter int RDW_W   = 7,
  parameter int MIN_VDW = 4,
  localparam int WORD_W = CAP_W + 1 + AUX_W + DIV_W + VDW_W + RDW_W
) (
  input  logic [CAP_W-1:0]  cap_sel,
  input  logic              duty_sel,
  input  logic [AUX_W-1:0]  aux_sel,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [VDW_W-1:0]  vco_div,
  input  logic [RDW_W-1:0]  ref_div,
  output logic [WORD_W-1:0] word,
  output logic              word_ok
);

  // Transmission order is fixed by the receiver: trim code leads, reference divider trails.
  always_comb begin
    word    = {cap_sel, duty_sel, aux_sel, div_sel, vco_div, ref_div};
    word_ok = (vco_div >= VDW_W'(MIN_VDW));
  end

endmodule

// File: rtl/cwt_timer.sv
module cwt_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/cwt_seq.sv
module cwt_seq
  import cwt_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 3,
  parameter int WAIT_CYC  = 3,
  parameter int STRB_CYC  = 10,
  parameter int LOCK_CYC  = 20,
  parameter int CW        = 5,
  localparam int NW       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              word_ok,
  input  logic              tm_zero,
  output logic              tm_load,
  output logic [CW-1:0]     tm_val,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_stb
);

  localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_WAIT  = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] LD_STRB  = CW'(STRB_CYC - 1);
  localparam logic [CW-1:0] LD_LOCK  = CW'((LOCK_CYC > 0) ? LOCK_CYC - 1 : 0);
  localparam logic [NW-1:0] LAST_IDX = NW'(WORD_W - 1);
  localparam bit            HAS_LOCK = (LOCK_CYC > 0);

  cwt_state_e        st;
  logic [WORD_W-1:0] sr;
  logic [NW-1:0]     nleft;

  always_comb begin
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st)
      ST_IDLE:  if (start && word_ok) begin tm_load = 1'b1; tm_val = LD_SETUP; end
      ST_SETUP: if (tm_zero) begin tm_load = 1'b1; tm_val = LD_HOLD; end
      ST_HIGH:  if (tm_zero) begin
                  tm_load = 1'b1;
                  tm_val  = (nleft == '0) ? LD_WAIT : LD_SETUP;
                end
      ST_GAP:   if (tm_zero) begin tm_load = 1'b1; tm_val = LD_STRB; end
      ST_STRB:  if (tm_zero && HAS_LOCK) begin tm_load = 1'b1; tm_val = LD_LOCK; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sr      <= '0;
      nleft   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
      ser_stb <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          if (word_ok) begin
            busy    <= 1'b1;
            ser_dat <= word[WORD_W-1];
            sr      <= word << 1;
            nleft   <= LAST_IDX;
            st      <= ST_SETUP;
          end else begin
            err <= 1'b1;
          end
        end
        ST_SETUP: if (tm_zero) begin
          ser_clk <= 1'b1;
          st      <= ST_HIGH;
        end
        ST_HIGH: if (tm_zero) begin
          ser_clk <= 1'b0;
          if (nleft == '0) begin
            ser_dat <= 1'b0;
            st      <= ST_GAP;
          end else begin
            ser_dat <= sr[WORD_W-1];
            sr      <= sr << 1;
            nleft   <= nleft - 1'b1;
            st      <= ST_SETUP;
          end
        end
        ST_GAP: if (tm_zero) begin
          ser_stb <= 1'b1;
          st      <= ST_STRB;
        end
        ST_STRB: if (tm_zero) begin
          ser_stb <= 1'b0;
          if (HAS_LOCK) begin
            st <= ST_LOCK;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_LOCK: if (tm_zero) begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_word_tx.sv
module cfg_word_tx
  import cwt_pkg::*;
#(
  parameter int CAP_W     = 2,
  parameter int AUX_W     = 2,
  parameter int DIV_W     = 3,
  parameter int VDW_W     = 9,
  parameter int RDW_W     = 7,
  parameter int MIN_VDW   = 4,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 3,
  parameter int WAIT_CYC  = 3,
  parameter int STRB_CYC  = 10,
  parameter int LOCK_CYC  = 20,
  localparam int WORD_W   = CAP_W + 1 + AUX_W + DIV_W + VDW_W + RDW_W,
  localparam int MAXC     = cwt_max(cwt_max(cwt_max(SETUP_CYC, HOLD_CYC),
                                            cwt_max(WAIT_CYC, STRB_CYC)), LOCK_CYC),
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CAP_W-1:0] cap_sel,
  input  logic             duty_sel,
  input  logic [AUX_W-1:0] aux_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [VDW_W-1:0] vco_div,
  input  logic [RDW_W-1:0] ref_div,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             ser_stb
);

  logic [WORD_W-1:0] word;
  logic              word_ok;
  logic              tm_load;
  logic [CW-1:0]     tm_val;
  logic              tm_zero;

  cwt_pack #(
    .CAP_W(CAP_W), .AUX_W(AUX_W), .DIV_W(DIV_W),
    .VDW_W(VDW_W), .RDW_W(RDW_W), .MIN_VDW(MIN_VDW)
  ) u_pack (
    .cap_sel(cap_sel), .duty_sel(duty_sel), .aux_sel(aux_sel),
    .div_sel(div_sel), .vco_div(vco_div), .ref_div(ref_div),
    .word(word), .word_ok(word_ok)
  );

  cwt_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .zero(tm_zero)
  );

  cwt_seq #(
    .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .WAIT_CYC(WAIT_CYC), .STRB_CYC(STRB_CYC), .LOCK_CYC(LOCK_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .word(word), .word_ok(word_ok),
    .tm_zero(tm_zero), .tm_load(tm_load), .tm_val(tm_val),
    .busy(busy), .done(done), .err(err),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb)
  );

endmodule

// File: rtl/cwt_chk.sv
module cwt_chk #(
  parameter int VW      = 9,
  parameter int MIN_VDW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [VW-1:0] vco_div,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          ser_clk,
  input logic          ser_dat,
  input logic          ser_stb
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_stb));

  p_stb_apart_r3: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> !ser_stb);

  p_dat_still_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(ser_clk) && ser_clk) |-> $stable(ser_dat));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (vco_div < VW'(MIN_VDW))) |=> (err && !busy));

  p_no_err_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !err);

endmodule

bind cfg_word_tx cwt_chk #(.VW(VDW_W), .MIN_VDW(MIN_VDW)) u_chk (.*);

// File: tb/sim_cfg_word_tx.sv
module sim_cfg_word_tx;
  localparam int SU = 3, HO = 3, WT = 3, SW = 10, LK = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] cap_sel = '0;
  logic       duty_sel = 1'b0;
  logic [1:0] aux_sel = '0;
  logic [2:0] div_sel = '0;
  logic [8:0] vco_div = '0;
  logic [6:0] ref_div = '0;
  logic busy, done, err, ser_clk, ser_dat, ser_stb;

  always #2 clk = ~clk;

  cfg_word_tx #(.SETUP_CYC(SU), .HOLD_CYC(HO), .WAIT_CYC(WT),
                .STRB_CYC(SW), .LOCK_CYC(LK)) u0 (
    .clk(clk), .rst(rst), .start(start), .cap_sel(cap_sel), .duty_sel(duty_sel),
    .aux_sel(aux_sel), .div_sel(div_sel), .vco_div(vco_div), .ref_div(ref_div),
    .busy(busy), .done(done), .err(err),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // passive monitor, samples on the falling edge
  logic p_clk = 0, p_dat = 0, p_stb = 0;
  int stab = 100, hi = 0, gap = 0, swid = 0, since = 0;
  bit armed = 0, hi_bad = 0;
  int nrise = 0, ndone = 0, nerr = 0;
  logic [23:0] cap = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !p_clk) begin
        chk(ser_dat == p_dat && stab >= SU, "R4 setup before rise", stab, SU);
        cap = {cap[22:0], ser_dat};
        nrise++;
        hi = 0;
        hi_bad = 0;
      end
      if (ser_clk) begin
        hi++;
        if (p_clk && ser_dat != p_dat) hi_bad = 1;
      end
      if (!ser_clk && p_clk) begin
        chk(hi >= HO && !hi_bad, "R5 high phase", hi, HO);
        gap = 0;
      end else gap++;
      if (ser_stb && ser_clk) chk(0, "R3 strobe with clock", 1, 0);
      if (ser_stb && !p_stb) begin
        chk(nrise == 24, "R3 strobe after all bits", nrise, 24);
        chk(gap >= WT, "R6 gap before strobe", gap, WT);
        swid = 0;
      end
      if (ser_stb) swid++;
      if (!ser_stb && p_stb) begin
        chk(swid >= SW, "R6 strobe width", swid, SW);
        since = 0;
        armed = 1;
      end else if (armed) since++;
      if (done) begin
        chk(armed && since == LK, "R7 settle delay", since, LK);
        chk(!busy, "R7 busy low at done", busy, 0);
        armed = 0;
        ndone++;
      end
      if (err) nerr++;
      stab = (ser_dat != p_dat) ? 1 : stab + 1;
      p_clk = ser_clk;
      p_dat = ser_dat;
      p_stb = ser_stb;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_fields(input logic [1:0] c, input logic t, input logic [1:0] a,
                            input logic [2:0] d, input logic [8:0] v, input logic [6:0] r);
    cap_sel = c; duty_sel = t; aux_sel = a; div_sel = d; vco_div = v; ref_div = r;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic xfer(input logic [1:0] c, input logic t, input logic [1:0] a,
                      input logic [2:0] d, input logic [8:0] v, input logic [6:0] r,
                      input logic [23:0] exp, input string tag);
    bit ok;
    int d0;
    @(negedge clk);
    set_fields(c, t, a, d, v, r);
    nrise = 0; cap = '0; d0 = ndone;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R7 busy after start", busy, 1);
    wait_done(ok);
    chk(ok, "R7 done reached", ok, 1);
    chk(cap == exp, tag, cap, exp);
    chk(nrise == 24, "R2 bit count", nrise, 24);
    @(negedge clk);
    chk(!done && !busy && !ser_clk && !ser_stb && !ser_dat, "R1 idle after done",
        {done, busy, ser_clk, ser_stb, ser_dat}, 0);
    chk(ndone == d0 + 1, "R7 one done per transfer", ndone - d0, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({busy, done, err, ser_clk, ser_dat, ser_stb} == 0, "R1 levels in reset",
        {busy, done, err, ser_clk, ser_dat, ser_stb}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, ser_clk, ser_dat, ser_stb} == 0, "R1 levels after reset",
        {busy, done, err, ser_clk, ser_dat, ser_stb}, 0);
  endtask

  task automatic t_example;
    xfer(2'b00, 1'b1, 2'b10, 3'b001, 9'd276, 7'd59,
         24'b00110001_10001010_00111011, "R2 known example word");
  endtask

  task automatic t_patterns;
    xfer(2'b11, 1'b1, 2'b11, 3'b111, 9'h1FF, 7'h7F, 24'hFFFFFF, "R2 all ones");
    xfer(2'b10, 1'b1, 2'b01, 3'b010, 9'b101010101, 7'b0101010,
         {2'b10, 1'b1, 2'b01, 3'b010, 9'b101010101, 7'b0101010}, "R2 alternating");
    xfer(2'b01, 1'b0, 2'b00, 3'b100, 9'd4, 7'd0,
         {2'b01, 1'b0, 2'b00, 3'b100, 9'd4, 7'd0}, "R8 boundary divider and bypass");
  endtask

  task automatic t_reject(input logic [8:0] v);
    int e0, d0;
    @(negedge clk);
    set_fields(2'b00, 1'b0, 2'b00, 3'b001, v, 7'd10);
    nrise = 0; e0 = nerr; d0 = ndone;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(err && !busy, "R8 err pulse on low divider", {err, busy}, 2'b10);
    @(negedge clk);
    chk(!err, "R8 err lasts one cycle", err, 0);
    repeat (40) @(negedge clk);
    chk(nrise == 0 && ndone == d0 && !busy, "R8 no transfer after refusal",
        nrise, 0);
    chk(nerr == e0 + 1, "R8 single err", nerr - e0, 1);
  endtask

  task automatic t_busy_start;
    bit ok;
    int e0, d0;
    @(negedge clk);
    set_fields(2'b01, 1'b1, 2'b10, 3'b011, 9'd300, 7'd45);
    nrise = 0; cap = '0; e0 = nerr; d0 = ndone;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    set_fields(2'b10, 1'b0, 2'b01, 3'b110, 9'd77, 7'd3);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    set_fields(2'b11, 1'b0, 2'b11, 3'b000, 9'd1, 7'd0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!err, "R9 no err while busy", err, 0);
    wait_done(ok);
    chk(ok, "R9 first transfer completes", ok, 1);
    chk(cap == {2'b01, 1'b1, 2'b10, 3'b011, 9'd300, 7'd45}, "R9 word kept from accepted start",
        cap, {2'b01, 1'b1, 2'b10, 3'b011, 9'd300, 7'd45});
    repeat (300) @(negedge clk);
    chk(nrise == 24 && ndone == d0 + 1 && nerr == e0, "R9 no second transfer",
        nrise, 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_example;
    t_patterns;
    t_reject(9'd3);
    t_reject(9'd0);
    t_busy_start;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule